// File: doc/BRIEF.md
# Wait-State Clock Gating Controller

This block parks a small processor subsystem in a low-power wait state and brings it back. A one-cycle request on `wait_req` stops the bus clock and the watchdog clock, while the free-running oscillator clock that feeds the block keeps running. A stop-select input, sampled together with the request, decides whether the peripheral clock is also stopped. Every stopped clock passes through a latch-based gate whose latch is open only while the oscillator is low, so no shortened pulse reaches a gated clock on entry or exit.

While parked, the block forces the bus strobes to their idle levels and freezes the address and data buses at the values they had on the request cycle. Only a hardware reset or a qualifying interrupt ends the state. A qualifying interrupt is requested, enabled, and has a level strictly above a 3-bit exit threshold. The bus clock-source selection is captured on the request cycle and is presented again on wake-up. A divided clock output follows the peripheral clock, so it keeps toggling or freezes depending on the stop-select input.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `wait_clk_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `in_wait_o` and `wake_o` are 0, `bclk_src_o` and `clkout_o` are 0, and all three gated clocks run.
- R2: When `wait_req` is 1 and the block is not parked, `in_wait_o` is 1 after that edge. From that edge on, `bclk_o` and `wdt_clk_o` stay low until the block leaves the state. The edge itself is the last gated rising edge.
- R3: `periph_stop` is sampled on the request edge. If it was 1, `pclk_o` stays low for the whole wait. If it was 0, `pclk_o` keeps toggling.
- R4: An active-low `rst_n` ends the wait state at once, without waiting for a clock edge.
- R5: The block leaves the wait state on a clock edge where `irq_req` and `irq_en` are both 1 and `irq_level` is greater than `exit_thresh`, compared as unsigned. In the cycle after that edge, `wake_o` is 1 for exactly one cycle. Any other interrupt input leaves the block parked.
- R6: An interrupt of level 0 never ends the wait state, even with a threshold of 0.
- R7: `bclk_src_o` follows `clk_src_sel` with one cycle of delay while the block is running. It keeps the value captured on the request edge for the whole wait and for the first cycle after wake-up.
- R8: While parked, `rd_n_o` and `wr_n_o` are 1 and `ale_o` is 0. `addr_o` and `data_o` hold the values `addr_i` and `data_i` had on the request edge. Otherwise all five outputs follow their inputs.
- R9: `clkout_o` toggles once every `CLKOUT_DIV` oscillator cycles while the peripheral clock runs. It holds its level while the peripheral clock is stopped.
- R10: A `wait_req` that arrives while the block is already parked has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wait_req | input | 1 | One-cycle request to enter the wait state |
| periph_stop | input | 1 | Stop the peripheral clock as well when parked |
| exit_thresh | input | 3 | Interrupt level that must be exceeded to wake |
| irq_req | input | 1 | Winning interrupt request is present |
| irq_en | input | 1 | Winning interrupt is enabled |
| irq_level | input | 3 | Priority level of the winning interrupt |
| clk_src_sel | input | 2 | Current bus clock-source selection |
| rd_n_i | input | 1 | Read strobe from the core, active low |
| wr_n_i | input | 1 | Write strobe from the core, active low |
| ale_i | input | 1 | Address-latch strobe from the core |
| addr_i | input | ADDR_W | Address bus from the core |
| data_i | input | DATA_W | Data bus from the core |
| bclk_o | output | 1 | Gated bus clock |
| wdt_clk_o | output | 1 | Gated watchdog clock |
| pclk_o | output | 1 | Gated peripheral clock |
| bclk_src_o | output | 2 | Clock-source selection applied to the bus clock |
| clkout_o | output | 1 | Divided peripheral clock for the clock output pin |
| rd_n_o | output | 1 | Read strobe to the pins |
| wr_n_o | output | 1 | Write strobe to the pins |
| ale_o | output | 1 | Address-latch strobe to the pins |
| addr_o | output | ADDR_W | Address bus to the pins |
| data_o | output | DATA_W | Data bus to the pins |
| in_wait_o | output | 1 | Block is in the wait state |
| wake_o | output | 1 | One-cycle pulse after an interrupt wake-up |

## Verification
Interrupts are applied while the block is parked, each with a different mix of enable, level and threshold. These cases are: below the threshold, above it but disabled, level 0 against a threshold of 0, level 7 against a threshold of 7, and just above the threshold. Together they separate a strict comparison from a non-strict one and show whether the enable is respected. Each wait is run once with the stop-select input at 0 and once at 1. Comparing `pclk_o` and `clkout_o` between the two runs shows whether that input is sampled on entry and acts only on the peripheral branch. The clock-source input is changed while the block is parked, which shows whether the captured value is restored on wake-up. A second wait request and a reset are each applied during a wait, one to confirm the request is ignored and one to confirm the reset exits without a clock edge.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  localparam int LVL_W    = 3;
  localparam int SRC_W    = 2;
  localparam int NUM_GCLK = 3;
  localparam int GC_BUS   = 0;
  localparam int GC_WDT   = 1;
  localparam int GC_PER   = 2;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [SRC_W-1:0] src_t;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic ale;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, ale: 1'b0};
endpackage

// File: rtl/wcc_clk_gate.sv
module wcc_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // latch open only during the low phase, so the AND never clips a high pulse
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/wcc_wait_fsm.sv
module wcc_wait_fsm
  import wcc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_req_i,
  input  logic periph_stop_i,
  input  lvl_t exit_thresh_i,
  input  logic irq_req_i,
  input  logic irq_en_i,
  input  lvl_t irq_level_i,
  input  src_t clk_src_sel_i,
  output logic in_wait_o,
  output logic pstop_o,
  output logic wake_o,
  output src_t src_hold_o
);
  logic in_wait_q, pstop_q, wake_q;
  src_t src_q;
  logic enter, leave;

  assign enter = wait_req_i && !in_wait_q;
  assign leave = in_wait_q && irq_req_i && irq_en_i && (irq_level_i > exit_thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_wait_q <= 1'b0;
      pstop_q   <= 1'b0;
      wake_q    <= 1'b0;
      src_q     <= '0;
    end else begin
      if (enter) begin
        in_wait_q <= 1'b1;
        pstop_q   <= periph_stop_i;
      end else if (leave) begin
        in_wait_q <= 1'b0;
      end
      wake_q <= leave;
      if (!in_wait_q) src_q <= clk_src_sel_i;
    end
  end

  assign in_wait_o  = in_wait_q;
  assign pstop_o    = pstop_q;
  assign wake_o     = wake_q;
  assign src_hold_o = src_q;
endmodule

// File: rtl/wcc_bus_hold.sv
module wcc_bus_hold
  import wcc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  strobe_t       strobe_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output strobe_t       strobe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (!hold_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign strobe_o = hold_i ? STROBE_IDLE : strobe_i;
  assign addr_o   = hold_i ? addr_q : addr_i;
  assign data_o   = hold_i ? data_q : data_i;
endmodule

// File: rtl/wcc_clkout_div.sv
module wcc_clkout_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clkout_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (run_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        out_q <= ~out_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clkout_o = out_q;
endmodule

// File: rtl/wait_clk_ctrl.sv
module wait_clk_ctrl
  import wcc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CLKOUT_DIV = 4
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              wait_req,
  input  logic              periph_stop,
  input  logic [LVL_W-1:0]  exit_thresh,
  input  logic              irq_req,
  input  logic              irq_en,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [SRC_W-1:0]  clk_src_sel,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bclk_o,
  output logic              wdt_clk_o,
  output logic              pclk_o,
  output logic [SRC_W-1:0]  bclk_src_o,
  output logic              clkout_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              ale_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              in_wait_o,
  output logic              wake_o
);
  logic in_wait_w, pstop_w, wake_w, per_run_w;
  src_t src_w;
  logic [NUM_GCLK-1:0] gate_en, gclk;
  strobe_t strobe_in, strobe_out;

  wcc_wait_fsm u_fsm (
    .clk_i         (clk_osc),
    .rst_ni        (rst_n),
    .wait_req_i    (wait_req),
    .periph_stop_i (periph_stop),
    .exit_thresh_i (exit_thresh),
    .irq_req_i     (irq_req),
    .irq_en_i      (irq_en),
    .irq_level_i   (irq_level),
    .clk_src_sel_i (clk_src_sel),
    .in_wait_o     (in_wait_w),
    .pstop_o       (pstop_w),
    .wake_o        (wake_w),
    .src_hold_o    (src_w)
  );

  assign per_run_w       = !(in_wait_w && pstop_w);
  assign gate_en[GC_BUS] = !in_wait_w;
  assign gate_en[GC_WDT] = !in_wait_w;
  assign gate_en[GC_PER] = per_run_w;

  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gate
    wcc_clk_gate u_gate (
      .clk_i  (clk_osc),
      .en_i   (gate_en[g]),
      .gclk_o (gclk[g])
    );
  end

  assign strobe_in = '{rd_n: rd_n_i, wr_n: wr_n_i, ale: ale_i};

  wcc_bus_hold #(.AW(ADDR_W), .DW(DATA_W)) u_bus (
    .clk_i    (clk_osc),
    .rst_ni   (rst_n),
    .hold_i   (in_wait_w),
    .strobe_i (strobe_in),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .strobe_o (strobe_out),
    .addr_o   (addr_o),
    .data_o   (data_o)
  );

  wcc_clkout_div #(.DIV(CLKOUT_DIV)) u_div (
    .clk_i    (clk_osc),
    .rst_ni   (rst_n),
    .run_i    (per_run_w),
    .clkout_o (clkout_o)
  );

  assign bclk_o     = gclk[GC_BUS];
  assign wdt_clk_o  = gclk[GC_WDT];
  assign pclk_o     = gclk[GC_PER];
  assign bclk_src_o = src_w;
  assign rd_n_o     = strobe_out.rd_n;
  assign wr_n_o     = strobe_out.wr_n;
  assign ale_o      = strobe_out.ale;
  assign in_wait_o  = in_wait_w;
  assign wake_o     = wake_w;
endmodule

// File: rtl/wcc_chk.sv
module wcc_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_osc,
  input logic              rst_n,
  input logic              wait_req,
  input logic [2:0]        exit_thresh,
  input logic              irq_req,
  input logic              irq_en,
  input logic [2:0]        irq_level,
  input logic              in_wait,
  input logic              pstop,
  input logic              wake,
  input logic [1:0]        bclk_src,
  input logic              clkout,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic              ale_o,
  input logic [ADDR_W-1:0] addr_o
);
  p_enter_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (wait_req && !in_wait) |=> in_wait);

  p_no_wake_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (in_wait && !(irq_req && irq_en && (irq_level > exit_thresh))) |=> in_wait);

  p_wake_pulse_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    wake |-> (!in_wait && $past(in_wait)));

  p_level0_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (in_wait && irq_level == 3'd0) |=> in_wait);

  p_src_hold_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    in_wait |=> $stable(bclk_src));

  p_idle_strobes_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    in_wait |-> (rd_n_o && wr_n_o && !ale_o));

  p_addr_hold_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    in_wait |=> (!in_wait || $stable(addr_o)));

  p_clkout_frozen_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (in_wait && pstop) |=> $stable(clkout));

  p_ignore_req_r10: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (in_wait && wait_req) |=> !wake || !$past(wait_req) || $past(irq_req));
endmodule

bind wait_clk_ctrl wcc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_osc     (clk_osc),
  .rst_n       (rst_n),
  .wait_req    (wait_req),
  .exit_thresh (exit_thresh),
  .irq_req     (irq_req),
  .irq_en      (irq_en),
  .irq_level   (irq_level),
  .in_wait     (in_wait_w),
  .pstop       (pstop_w),
  .wake        (wake_w),
  .bclk_src    (bclk_src_o),
  .clkout      (clkout_o),
  .rd_n_o      (rd_n_o),
  .wr_n_o      (wr_n_o),
  .ale_o       (ale_o),
  .addr_o      (addr_o)
);

// File: tb/wait_clk_ctrl_bench.sv
`timescale 1ns/1ps
module wait_clk_ctrl_bench;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int DIV = 4;

  logic clk_osc = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 1'b0, periph_stop = 1'b0, irq_req = 1'b0, irq_en = 1'b0;
  logic [2:0] exit_thresh = 3'd0, irq_level = 3'd0;
  logic [1:0] clk_src_sel = 2'd3;
  logic rd_n_i = 1'b1, wr_n_i = 1'b1, ale_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic bclk_o, wdt_clk_o, pclk_o, clkout_o, rd_n_o, wr_n_o, ale_o, in_wait_o, wake_o;
  logic [1:0] bclk_src_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_osc = ~clk_osc;

  wait_clk_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLKOUT_DIV(DIV)) u_wait_clk_ctrl (
    .clk_osc(clk_osc), .rst_n(rst_n), .wait_req(wait_req), .periph_stop(periph_stop),
    .exit_thresh(exit_thresh), .irq_req(irq_req), .irq_en(irq_en), .irq_level(irq_level),
    .clk_src_sel(clk_src_sel), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .ale_i(ale_i),
    .addr_i(addr_i), .data_i(data_i), .bclk_o(bclk_o), .wdt_clk_o(wdt_clk_o),
    .pclk_o(pclk_o), .bclk_src_o(bclk_src_o), .clkout_o(clkout_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .ale_o(ale_o), .addr_o(addr_o), .data_o(data_o),
    .in_wait_o(in_wait_o), .wake_o(wake_o)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  bit m_wait, m_pstop, m_wake, m_clkout, e_bclk, e_pclk, old_wait, run_p;
  int m_src, m_addr, m_data, m_cnt;

  initial begin
    forever begin
      @(posedge clk_osc);
      if (!rst_n) begin
        m_wait = 0; m_pstop = 0; m_wake = 0; m_src = 0; m_addr = 0; m_data = 0;
        m_cnt = 0; m_clkout = 0; e_bclk = 1; e_pclk = 1;
      end else begin
        old_wait = m_wait;
        run_p  = !(m_wait && m_pstop);
        e_bclk = !m_wait;
        e_pclk = run_p;
        if (!old_wait) begin
          m_src = int'(clk_src_sel); m_addr = int'(addr_i); m_data = int'(data_i);
        end
        m_wake = old_wait && irq_req && irq_en && (int'(irq_level) > int'(exit_thresh));
        if (!old_wait && wait_req) begin
          m_wait = 1; m_pstop = periph_stop;
        end else if (m_wake) begin
          m_wait = 0;
        end
        if (run_p) begin
          if (m_cnt == DIV - 1) begin m_cnt = 0; m_clkout = !m_clkout; end
          else m_cnt++;
        end
      end
      #1;
      check("R2", "in_wait_o", in_wait_o, m_wait);
      check("R2", "bclk_o", bclk_o, e_bclk);
      check("R2", "wdt_clk_o", wdt_clk_o, e_bclk);
      check("R3", "pclk_o", pclk_o, e_pclk);
      check("R5", "wake_o", wake_o, m_wake);
      check("R7", "bclk_src_o", bclk_src_o, m_src);
      check("R8", "rd_n_o", rd_n_o, m_wait ? 1 : rd_n_i);
      check("R8", "wr_n_o", wr_n_o, m_wait ? 1 : wr_n_i);
      check("R8", "ale_o", ale_o, m_wait ? 0 : ale_i);
      check("R8", "addr_o", addr_o, m_wait ? m_addr : int'(addr_i));
      check("R8", "data_o", data_o, m_wait ? m_data : int'(data_i));
      check("R9", "clkout_o", clkout_o, m_clkout);
    end
  end

  // bus activity pattern, changes on every falling edge
  initial begin
    for (int k = 1; ; k++) begin
      @(negedge clk_osc);
      addr_i = AW'(k * 16'h1357);
      data_i = DW'(k * 16'h0b2d + 5);
      rd_n_i = k[0];
      wr_n_i = !k[0];
      ale_i  = k[1];
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_osc);
  endtask

  task automatic pulse_wait();
    wait_req = 1'b1; step(1); wait_req = 1'b0;
  endtask

  task automatic pulse_irq(input logic en, input logic [2:0] lvl);
    irq_req = 1'b1; irq_en = en; irq_level = lvl; step(1);
    irq_req = 1'b0; irq_en = 1'b0; irq_level = 3'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    finish_run();
  end

  initial begin
    step(2);
    // R1: state held at reset values while reset is low, selection input ignored
    check("R1", "in_wait_o in reset", in_wait_o, 0);
    check("R1", "bclk_src_o in reset", bclk_src_o, 0);
    check("R1", "clkout_o in reset", clkout_o, 0);
    rst_n = 1'b1;
    step(3);

    // threshold 3, peripheral clock kept running
    exit_thresh = 3'd3; periph_stop = 1'b0; clk_src_sel = 2'd2;
    step(2);
    pulse_wait();
    clk_src_sel = 2'd1;
    step(6);
    pulse_irq(1'b1, 3'd2);      // below threshold
    step(2);
    pulse_irq(1'b0, 3'd5);      // above but disabled
    step(2);
    check("R5", "in_wait_o after rejected irqs", in_wait_o, 1);
    pulse_wait();               // R10: repeated request while parked
    step(2);
    check("R10", "in_wait_o after repeated request", in_wait_o, 1);
    check("R10", "wake_o after repeated request", wake_o, 0);
    pulse_irq(1'b1, 3'd3);      // equal to threshold, not enough
    step(1);
    pulse_irq(1'b1, 3'd4);      // just above threshold
    step(6);

    // threshold 0, peripheral clock stopped
    exit_thresh = 3'd0; periph_stop = 1'b1;
    pulse_wait();
    periph_stop = 1'b0;
    step(9);
    pulse_irq(1'b1, 3'd0);
    step(1);
    @(posedge clk_osc); #1;
    check("R6", "in_wait_o after level-0 irq", in_wait_o, 1);
    step(1);
    pulse_irq(1'b1, 3'd1);
    step(6);

    // reset while parked
    periph_stop = 1'b1;
    pulse_wait();
    step(4);
    rst_n = 1'b0;
    #1;
    check("R4", "in_wait_o immediately after reset", in_wait_o, 0);
    step(2);
    rst_n = 1'b1;
    step(4);

    // threshold 7: nothing can wake, then reset exits
    exit_thresh = 3'd7; periph_stop = 1'b0; clk_src_sel = 2'd3;
    step(2);
    pulse_wait();
    step(3);
    pulse_irq(1'b1, 3'd7);
    step(2);
    check("R5", "in_wait_o at level 7 vs threshold 7", in_wait_o, 1);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(8);
    finish_run();
  end
endmodule